// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block sits between an 8-bit console's buses and the ROM of a cartridge. It maps CPU program fetches and pattern-table fetches into a larger ROM through small banked windows. The CPU selects banks by writing to the upper half of its address space. A command write picks one of eight bank registers and sets two layout mode bits. A data write then loads the picked register. A separate write sets the nametable mirroring select.

The program space from 0x8000 to 0xFFFF is split into four 8 KB windows. Two registers drive two of these windows. The remaining two windows are pinned to the last two banks of the program ROM. The 8 KB pattern space is split into eight 1 KB windows. Two registers each drive a pair of 1 KB windows, and four registers each drive one 1 KB window. One mode bit swaps the two halves of the pattern space. The other mode bit swaps which program window is pinned.

Address translation is combinational from the stored state, so a register or mode change affects the next lookup after the write's clock edge. Bank numbers are cut to the configured ROM sizes when they are stored.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write (`wr_en` high) to an even address in 0x8000-0x9FFF loads the command. Data bits 2:0 select the bank register, bit 6 is the program swap mode and bit 7 is the pattern inversion mode.
- R2: A write to an odd address in 0x8000-0x9FFF stores `wr_data` into the register selected by the command. No register changes while `wr_en` is low.
- R3: Pattern slots 0/1 (offsets 0x000 and 0x400) use register 0 with bit 0 forced to 0 and to 1. Slots 2/3 (0x800 and 0xC00) do the same with register 1.
- R4: Pattern slots 4-7 (0x1000, 0x1400, 0x1800, 0x1C00) use registers 2, 3, 4 and 5.
- R5: With the inversion mode set, pattern address bit 12 is flipped before the slot is chosen, so registers 0/1 serve 0x1000-0x1FFF and registers 2-5 serve 0x0000-0x0FFF.
- R6: Program window 0xA000 uses register 7 and 0xE000 uses the last bank. With swap mode clear, 0x8000 uses register 6 and 0xC000 uses the second-to-last bank. With swap mode set, these two are exchanged.
- R7: A change of either mode bit remaps all windows on the next lookup from the stored register values, with no data rewrite.
- R8: A write to an even address in 0xA000-0xBFFF sets `nt_mirror` to data bit 0. Odd addresses there, and writes outside 0x8000-0xBFFF, change neither the mirroring nor any bank.
- R9: Registers 0-5 keep their low `CHR_BANK_BITS` bits and registers 6-7 keep their low `PRG_BANK_BITS` bits. The rest are dropped.
- R10: Reset clears the command and all eight registers to zero and sets `nt_mirror` to `MIRROR_RST`.
- R11: Program output bits 12:0 equal the input offset bits 12:0. Pattern output bits 9:0 equal input bits 9:0. The bank number forms the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_cpu_addr | input | 15 | CPU fetch address bits 14:0 (fetch in 0x8000-0xFFFF) |
| prg_rom_addr | output | PRG_BANK_BITS+13 | Banked program ROM address |
| chr_ppu_addr | input | 13 | Pattern-table fetch address |
| chr_rom_addr | output | CHR_BANK_BITS+10 | Banked pattern ROM address |
| nt_mirror | output | 1 | Nametable mirroring select |

## Verification
The assertions assume that `prg_cpu_addr` and `chr_ppu_addr` are stable around each rising edge. They also assume the outputs are sampled at that edge, since translation has no register stage. The bench changes every input one nanosecond after a rising edge and compares at the falling edge. A behavioural model tracks the command, the eight banks and the mirroring bit, and the bench checks the outputs against it on every cycle. Write addresses cover both ends of each decoded range, odd and even, plus addresses outside the range and cycles with the strobe low.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   localparam int NUM_BANK_REGS = 8;
   localparam int NUM_CHR_REGS  = 6;
   localparam int NUM_PRG_REGS  = 2;

   typedef struct packed {
      logic       chr_inv;
      logic       prg_swap;
      logic [2:0] sel;
   } cmd_t;

   typedef enum logic [1:0] {
      PWIN_8000 = 2'd0,
      PWIN_A000 = 2'd1,
      PWIN_C000 = 2'd2,
      PWIN_E000 = 2'd3
   } prg_win_e;
endpackage

// File: rtl/bank_reg_file.sv
module bank_reg_file
   import mapper_pkg::*;
#(
   parameter int PRG_BANK_BITS = 5,
   parameter int CHR_BANK_BITS = 7,
   parameter bit MIRROR_RST    = 1'b0
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        cmd_wr,
   input  logic                                        data_wr,
   input  logic                                        mir_wr,
   input  logic [7:0]                                  wr_data,
   output cmd_t                                        cmd_q,
   output logic [NUM_CHR_REGS-1:0][CHR_BANK_BITS-1:0]  chr_bank,
   output logic [NUM_PRG_REGS-1:0][PRG_BANK_BITS-1:0]  prg_bank,
   output logic                                        mirror_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cmd_wr) begin
         cmd_q.chr_inv  <= wr_data[7];
         cmd_q.prg_swap <= wr_data[6];
         cmd_q.sel      <= wr_data[2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mirror_q <= MIRROR_RST;
      else if (mir_wr) mirror_q <= wr_data[0];
   end

   for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_reg
      if (i < NUM_CHR_REGS) begin : g_chr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chr_bank[i] <= '0;
            else if (data_wr && cmd_q.sel == 3'(i))
               chr_bank[i] <= wr_data[CHR_BANK_BITS-1:0];
         end
      end else begin : g_prg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prg_bank[i-NUM_CHR_REGS] <= '0;
            else if (data_wr && cmd_q.sel == 3'(i))
               prg_bank[i-NUM_CHR_REGS] <= wr_data[PRG_BANK_BITS-1:0];
         end
      end
   end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
   import mapper_pkg::*;
#(
   parameter int PRG_BANK_BITS = 5,
   localparam int PRG_AW = PRG_BANK_BITS + 13
) (
   input  logic                                        prg_swap,
   input  logic [NUM_PRG_REGS-1:0][PRG_BANK_BITS-1:0]  prg_bank,
   input  logic [14:0]                                 prg_cpu_addr,
   output logic [PRG_AW-1:0]                           prg_rom_addr
);
   localparam logic [PRG_BANK_BITS-1:0] LAST_BANK = '1;
   localparam logic [PRG_BANK_BITS-1:0] PEN_BANK  = LAST_BANK - 1'b1;

   prg_win_e                 win;
   logic [PRG_BANK_BITS-1:0] bank;

   assign win = prg_win_e'(prg_cpu_addr[14:13]);

   always_comb begin
      unique case (win)
         PWIN_8000: bank = prg_swap ? PEN_BANK : prg_bank[0];
         PWIN_A000: bank = prg_bank[1];
         PWIN_C000: bank = prg_swap ? prg_bank[0] : PEN_BANK;
         default:   bank = LAST_BANK;
      endcase
   end

   assign prg_rom_addr = {bank, prg_cpu_addr[12:0]};
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
   import mapper_pkg::*;
#(
   parameter int CHR_BANK_BITS = 7,
   localparam int CHR_AW = CHR_BANK_BITS + 10
) (
   input  logic                                        chr_inv,
   input  logic [NUM_CHR_REGS-1:0][CHR_BANK_BITS-1:0]  chr_bank,
   input  logic [12:0]                                 chr_ppu_addr,
   output logic [CHR_AW-1:0]                           chr_rom_addr
);
   localparam logic [CHR_BANK_BITS-1:0] LSB = CHR_BANK_BITS'(1);

   logic [7:0][CHR_BANK_BITS-1:0] win_bank;
   logic [2:0]                    slot;

   for (genvar w = 0; w < 8; w++) begin : g_win
      if (w < 4) begin : g_pair
         assign win_bank[w] = (chr_bank[w/2] & ~LSB) | ((w % 2 == 1) ? LSB : '0);
      end else begin : g_single
         assign win_bank[w] = chr_bank[w-2];
      end
   end

   assign slot         = chr_ppu_addr[12:10] ^ {chr_inv, 2'b00};
   assign chr_rom_addr = {win_bank[slot], chr_ppu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import mapper_pkg::*;
#(
   parameter int PRG_BANK_BITS = 5,
   parameter int CHR_BANK_BITS = 7,
   parameter bit MIRROR_RST    = 1'b0,
   localparam int PRG_AW = PRG_BANK_BITS + 13,
   localparam int CHR_AW = CHR_BANK_BITS + 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [14:0]       prg_cpu_addr,
   output logic [PRG_AW-1:0] prg_rom_addr,
   input  logic [12:0]       chr_ppu_addr,
   output logic [CHR_AW-1:0] chr_rom_addr,
   output logic              nt_mirror
);
   if (PRG_BANK_BITS < 1 || PRG_BANK_BITS > 8) begin : g_bad_prg
      $error("PRG_BANK_BITS must lie in 1..8");
   end
   if (CHR_BANK_BITS < 2 || CHR_BANK_BITS > 8) begin : g_bad_chr
      $error("CHR_BANK_BITS must lie in 2..8");
   end

   cmd_t                                        cmd_q;
   logic [NUM_CHR_REGS-1:0][CHR_BANK_BITS-1:0]  chr_bank;
   logic [NUM_PRG_REGS-1:0][PRG_BANK_BITS-1:0]  prg_bank;
   logic                                        in_cmd_rng;
   logic                                        in_mir_rng;
   logic                                        cmd_wr;
   logic                                        data_wr;
   logic                                        mir_wr;
   logic                                        unused_addr_bits;

   assign in_cmd_rng       = (wr_addr[15:13] == 3'b100);
   assign in_mir_rng       = (wr_addr[15:13] == 3'b101);
   assign cmd_wr           = wr_en && in_cmd_rng && !wr_addr[0];
   assign data_wr          = wr_en && in_cmd_rng &&  wr_addr[0];
   assign mir_wr           = wr_en && in_mir_rng && !wr_addr[0];
   assign unused_addr_bits = ^{wr_addr[12:1], wr_data};

   bank_reg_file #(
      .PRG_BANK_BITS(PRG_BANK_BITS),
      .CHR_BANK_BITS(CHR_BANK_BITS),
      .MIRROR_RST   (MIRROR_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_wr  (cmd_wr),
      .data_wr (data_wr),
      .mir_wr  (mir_wr),
      .wr_data (wr_data),
      .cmd_q   (cmd_q),
      .chr_bank(chr_bank),
      .prg_bank(prg_bank),
      .mirror_q(nt_mirror)
   );

   prg_window_map #(.PRG_BANK_BITS(PRG_BANK_BITS)) u_prg (
      .prg_swap    (cmd_q.prg_swap),
      .prg_bank    (prg_bank),
      .prg_cpu_addr(prg_cpu_addr),
      .prg_rom_addr(prg_rom_addr)
   );

   chr_window_map #(.CHR_BANK_BITS(CHR_BANK_BITS)) u_chr (
      .chr_inv     (cmd_q.chr_inv),
      .chr_bank    (chr_bank),
      .chr_ppu_addr(chr_ppu_addr),
      .chr_rom_addr(chr_rom_addr)
   );
endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
   parameter int PRG_BANK_BITS = 5,
   parameter int CHR_BANK_BITS = 7,
   localparam int PRG_AW = PRG_BANK_BITS + 13,
   localparam int CHR_AW = CHR_BANK_BITS + 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [15:0]       wr_addr,
   input logic [7:0]        wr_data,
   input logic [14:0]       prg_cpu_addr,
   input logic [PRG_AW-1:0] prg_rom_addr,
   input logic [12:0]       chr_ppu_addr,
   input logic [CHR_AW-1:0] chr_rom_addr,
   input logic              nt_mirror,
   input logic              chr_inv,
   input logic              prg_swap
);
   localparam logic [PRG_BANK_BITS-1:0] LAST_BANK = '1;
   localparam logic [PRG_BANK_BITS-1:0] PEN_BANK  = LAST_BANK - 1'b1;

   logic mir_strobe;
   assign mir_strobe = wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0];

   // R6
   e000_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_cpu_addr[14:13] == 2'b11 |-> prg_rom_addr[PRG_AW-1:13] == LAST_BANK);

   // R6
   pinned_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_cpu_addr[14:13] == {~prg_swap, 1'b0}) |-> prg_rom_addr[PRG_AW-1:13] == PEN_BANK);

   // R11
   prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_rom_addr[12:0] == prg_cpu_addr[12:0]);

   // R11
   chr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_rom_addr[9:0] == chr_ppu_addr[9:0]);

   // R3
   pair_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_ppu_addr[12] == chr_inv) |-> chr_rom_addr[10] == chr_ppu_addr[10]);

   // R8
   mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mir_strobe |=> $stable(nt_mirror));

   // R8
   mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mir_strobe |=> nt_mirror == $past(wr_data[0]));
endmodule

bind cart_bank_mapper mapper_chk #(
   .PRG_BANK_BITS(PRG_BANK_BITS),
   .CHR_BANK_BITS(CHR_BANK_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .prg_cpu_addr(prg_cpu_addr),
   .prg_rom_addr(prg_rom_addr),
   .chr_ppu_addr(chr_ppu_addr),
   .chr_rom_addr(chr_rom_addr),
   .nt_mirror   (nt_mirror),
   .chr_inv     (cmd_q.chr_inv),
   .prg_swap    (cmd_q.prg_swap)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/100ps
module sim_cart_bank_mapper;
   localparam int PB = 5;
   localparam int CB = 7;
   localparam int PB_N = 1 << PB;
   localparam int CB_N = 1 << CB;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [15:0]       wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic [14:0]       prg_cpu_addr = '0;
   logic [12:0]       chr_ppu_addr = '0;
   logic [PB+12:0]    prg_rom_addr;
   logic [CB+9:0]     chr_rom_addr;
   logic              nt_mirror;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // behavioural model state
   int m_sel, m_swap, m_inv, m_mir;
   int m_reg[8];

   always #2.5 clk = ~clk;

   cart_bank_mapper #(.PRG_BANK_BITS(PB), .CHR_BANK_BITS(CB), .MIRROR_RST(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prg_cpu_addr(prg_cpu_addr), .prg_rom_addr(prg_rom_addr),
      .chr_ppu_addr(chr_ppu_addr), .chr_rom_addr(chr_rom_addr), .nt_mirror(nt_mirror)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_prg(int a);
      int w = (a >> 13) & 3;
      int b;
      case (w)
         0: b = m_swap ? PB_N - 2 : m_reg[6];
         1: b = m_reg[7];
         2: b = m_swap ? m_reg[6] : PB_N - 2;
         default: b = PB_N - 1;
      endcase
      b = ((b % PB_N) + PB_N) % PB_N;
      return b * 8192 + (a & 8191);
   endfunction

   function automatic int exp_chr(int a);
      int s = (a >> 10) & 7;
      int b;
      if (m_inv != 0) s = s ^ 4;
      if (s < 4) b = (m_reg[s / 2] & ~1) | (s & 1);
      else       b = m_reg[s - 2];
      return (b % CB_N) * 1024 + (a & 1023);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 0; m_swap = 0; m_inv = 0; m_mir = 0;
         foreach (m_reg[i]) m_reg[i] = 0;
      end else if (wr_en) begin
         if (wr_addr >= 16'h8000 && wr_addr <= 16'h9FFF) begin
            if (wr_addr % 2 == 0) begin
               m_sel  = wr_data & 7;
               m_swap = (wr_data >> 6) & 1;
               m_inv  = (wr_data >> 7) & 1;
            end else begin
               m_reg[m_sel] = wr_data;
            end
         end else if (wr_addr >= 16'hA000 && wr_addr <= 16'hBFFF && wr_addr % 2 == 0) begin
            m_mir = wr_data & 1;
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int s;
         s = (chr_ppu_addr >> 10) ^ (m_inv * 4);
         chk("R6 model prg", prg_rom_addr, exp_prg(prg_cpu_addr));
         chk(m_inv != 0 ? "R5 model chr" : (s < 4 ? "R3 model chr" : "R4 model chr"),
             chr_rom_addr, exp_chr(chr_ppu_addr));
         chk("R8 model mirror", nt_mirror, m_mir);
      end
   end

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic look(int pa, int ca);
      @(posedge clk); #1;
      prg_cpu_addr = 15'(pa); chr_ppu_addr = 13'(ca);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: reset state
      look(15'h0000, 13'h0400);
      chk("R10 prg 0x8000 bank 0", prg_rom_addr, 0);
      chk("R10 chr slot1 bank 1", chr_rom_addr, 1 * 1024);
      chk("R10 mirror reset", nt_mirror, 0);
      look(15'h4000, 13'h1000);
      chk("R10 prg 0xC000 pinned", prg_rom_addr, 30 * 8192);
      chk("R10 chr slot4 bank 0", chr_rom_addr, 0);

      // R1 R2: load all eight registers
      begin
         int vals[8] = '{8'h13, 8'h26, 8'h31, 8'h44, 8'h5A, 8'hFF, 8'h47, 8'h0A};
         for (int i = 0; i < 8; i++) begin
            wr(16'h8000, i);
            wr(16'h8001, vals[i]);
         end
      end

      look(15'h0123, 13'h0015);
      chk("R6 R9 prg 0x8123", prg_rom_addr, 7 * 8192 + 'h123);
      chk("R3 chr slot0", chr_rom_addr, 'h12 * 1024 + 'h15);
      look(15'h2001, 13'h07FF);
      chk("R6 prg 0xA000 reg7", prg_rom_addr, 10 * 8192 + 1);
      chk("R3 chr slot1 lsb set", chr_rom_addr, 'h13 * 1024 + 'h3FF);
      look(15'h7FFF, 13'h0C02);
      chk("R6 R11 prg 0xFFFF", prg_rom_addr, 31 * 8192 + 'h1FFF);
      chk("R3 chr slot3", chr_rom_addr, 'h27 * 1024 + 2);
      look(15'h4000, 13'h1C01);
      chk("R6 prg 0xC000 pen", prg_rom_addr, 30 * 8192);
      chk("R4 R9 chr slot7", chr_rom_addr, 'h7F * 1024 + 1);
      look(15'h0000, 13'h1400);
      chk("R4 chr slot5", chr_rom_addr, 'h44 * 1024);

      // R7: swap mode, no data rewrite
      wr(16'h8000, 8'h40);
      look(15'h4005, 13'h1800);
      chk("R7 prg 0xC000 reg6", prg_rom_addr, 7 * 8192 + 5);
      chk("R4 chr slot6", chr_rom_addr, 'h5A * 1024);
      look(15'h0000, 13'h0000);
      chk("R7 prg 0x8000 pen", prg_rom_addr, 30 * 8192);

      // R5: inversion
      wr(16'h8000, 8'hC0);
      look(15'h6000, 13'h1000);
      chk("R5 chr 0x1000 reg0", chr_rom_addr, 'h12 * 1024);
      chk("R6 prg 0xE000 last", prg_rom_addr, 31 * 8192);
      look(15'h0000, 13'h0000);
      chk("R5 chr 0x0000 reg2", chr_rom_addr, 'h31 * 1024);

      // R2: data write in swap mode goes to the swapped window
      wr(16'h8000, 8'hC6);
      wr(16'h8001, 8'h03);
      look(15'h4000, 13'h1400);
      chk("R2 prg 0xC000 reg6", prg_rom_addr, 3 * 8192);
      chk("R5 chr 0x1400 slot1", chr_rom_addr, 'h13 * 1024);

      // R8: mirroring
      wr(16'hA000, 8'h01);
      look(15'h4000, 13'h0000);
      chk("R8 mirror set", nt_mirror, 1);
      wr(16'hA001, 8'h00);
      look(15'h4000, 13'h0000);
      chk("R8 odd write ignored", nt_mirror, 1);
      wr(16'hC000, 8'h00);
      wr(16'h6001, 8'h09);
      look(15'h4000, 13'h0000);
      chk("R8 out-of-range mirror", nt_mirror, 1);
      chk("R8 out-of-range prg", prg_rom_addr, 3 * 8192);

      // R2: strobe low ignored
      @(posedge clk); #1;
      wr_addr = 16'h8001; wr_data = 8'h55; wr_en = 1'b0;
      look(15'h4000, 13'h0000);
      chk("R2 no write when strobe low", prg_rom_addr, 3 * 8192);

      // R1: range-top addresses, modes cleared
      wr(16'h9FFE, 8'h07);
      wr(16'h9FFF, 8'h11);
      look(15'h2000, 13'h0000);
      chk("R1 R2 prg reg7 via 0x9FFF", prg_rom_addr, 17 * 8192);
      chk("R1 inversion cleared", chr_rom_addr, 'h12 * 1024);
      look(15'h0000, 13'h0000);
      chk("R1 swap cleared", prg_rom_addr, 3 * 8192);
      wr(16'hBFFE, 8'h00);
      look(15'h0000, 13'h0000);
      chk("R8 mirror clear at 0xBFFE", nt_mirror, 0);
      wr(16'hA000, 8'h01);

      // R10: reset mid-run
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      look(15'h2000, 13'h0400);
      chk("R10 prg reg7 cleared", prg_rom_addr, 0);
      chk("R10 chr reg0 cleared", chr_rom_addr, 1 * 1024);
      chk("R10 mirror back to reset", nt_mirror, 0);

      // sweep under the model
      for (int k = 0; k < 64; k++) begin
         wr(16'h8000 | ((k * 37) & 8'hC7) << 0, (k * 37) & 8'hC7);
         wr(16'h8001, (k * 91 + 5) & 8'hFF);
         look((k * 1237) & 15'h7FFF, (k * 613) & 13'h1FFF);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule